// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This fetch-stage block takes a window of instruction bytes that starts at the current program counter and turns it into one aligned instruction. The instruction set is byte-oriented and its instructions take 1 to 7 bytes. The block reads the leading byte and sorts it into a length class. A few lead bytes are exceptions. In the 0x80–0xBF row, for example, the length depends on whether the two 2-bit register fields of the byte are equal.

Each length class gathers its bytes into a 32-bit opcode word and a 24-bit extension word by its own rule. Opcode bytes are taken big-endian. 16-bit and 32-bit immediates are read little-endian. Long immediates are split across the two words. Along with the words, the block reports the length, an illegal-opcode flag and the address of the following instruction.

The upstream fetch buffer offers a window with a valid signal. The window is taken when the consumer is ready, and the result appears in registers one cycle later. The block has no state other than the output register.

Top module: `vlen_aligner`

## Requirements
- R1: While reset is held, and after it is released until the first accepted window, `out_valid` is low.
- R2: Lead bytes 0x00, 0x04, 0x08, 0x0C, 0x10–0x1F, 0x3C–0x41, 0x44, 0x45, 0x48, 0x49, 0x4C, 0x4D, 0x50–0x57, 0x60–0x7F, 0xCB, 0xD0–0xDB, 0xE0–0xEF and 0xFF give length 1 and opcode = zero-extended byte0.
- R3: For lead bytes 0x80–0xBF, if bits [3:2] equal bits [1:0], the length is 2 and opcode = {byte0, byte1}. Otherwise the length is 1 and opcode = byte0.
- R4: Lead bytes 0x20–0x23, 0x28–0x2B, 0x42, 0x43, 0x46, 0x47, 0x4A, 0x4B, 0x4E, 0x4F, 0x58–0x5F, 0xC0–0xCA, 0xCE, 0xCF and 0xF0–0xF6 give length 2 and opcode = {byte0, byte1}.
- R5: Lead bytes 0x01–0x03, 0x05–0x07, 0x09–0x0B, 0x0D–0x0F, 0x24–0x27, 0x2C–0x3B and 0xCC give length 3 and opcode = {byte0, byte2, byte1}.
- R6: Lead bytes 0xDE, 0xDF, 0xF8 and 0xF9 give length 3 and opcode = {byte0, byte1, byte2}.
- R7: Lead bytes 0xFA and 0xFB give length 4. When ({byte0,byte1} & 0xFFFC) is 0xFAF0, 0xFAF4 or 0xFAF8, opcode = {byte0, byte1, byte2, byte3}. Otherwise opcode = {byte0, byte1, byte3, byte2}.
- R8: Lead byte 0xCD gives length 5, opcode = {byte0, byte2, byte1, byte3} and ext = byte4. Lead byte 0xDC gives length 5, opcode = {byte0, byte4, byte3, byte2} and ext = byte1.
- R9: Lead bytes 0xFC and 0xFD give length 6, opcode = {byte0, byte1, byte5, byte4} and ext = {byte3, byte2}.
- R10: Lead byte 0xDD gives length 7, opcode = {byte0, byte4, byte3, byte2} and ext = {byte1, byte5, byte6}. Lead byte 0xFE gives length 7, opcode = {byte0, byte1, byte5, byte4} and ext = {byte3, byte2, byte6}.
- R11: For a legal lead byte, `out_next_pc` is `in_pc` + length, modulo 2^PC_W. Any other lead byte (only 0xF7) gives `out_illegal` = 1, length 0, zero opcode and zero ext, and `out_next_pc` = `in_pc`. In every case the bits of the opcode and ext words above the packed bytes are zero.
- R12: `in_ready` equals `out_ready`. A window is taken when `in_valid` and `out_ready` are both high, and its result is on the outputs with `out_valid` high after the next clock edge. When `out_ready` is high and nothing is taken, `out_valid` falls.
- R13: While `out_valid` is high and `out_ready` is low, every output holds its value and the input window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Window and PC are valid |
| in_ready | output | 1 | Block can take a window this cycle |
| in_pc | input | PC_W | Address of byte 0 |
| in_window | input | 8*WIN_BYTES | Instruction bytes; byte i in bits [8i+7:8i] |
| out_valid | output | 1 | Aligned result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_len | output | 3 | Instruction length in bytes, 0 when illegal |
| out_opcode | output | 32 | Packed opcode word |
| out_ext | output | 24 | Packed extension word |
| out_illegal | output | 1 | Lead byte has no defined length |
| out_next_pc | output | PC_W | Address of the following instruction |

## Verification
Each result belongs to the window taken at one rising edge and is due on the outputs right after that edge. The bench samples it at the falling edge that follows. The reference model keeps its expected output register, updated at each rising edge from the same handshake rule. Every falling edge compares the whole output set against that register, so a result that comes a cycle early or late, or that changes while stalled, fails in the cycle it happens. `in_ready` is combinational and is compared in the same cycle as `out_ready`.

// File: rtl/vla_pkg.sv
// Package: shared kinds and widths for the variable-length aligner.
// Assumes lead-byte classes are fixed at design time.
package vla_pkg;

    localparam int OPC_W = 32;
    localparam int EXT_W = 24;
    localparam int LEN_W = 3;

    // Length/packing class chosen from the lead byte.
    typedef enum logic [3:0] {
        K_ILL, K_B1, K_B2, K_B3_LE, K_B3_BE, K_B4,
        K_B5_CD, K_B5_DC, K_B6, K_B7_DD, K_B7_FE
    } vla_kind_t;

    // Byte count of a class; zero for the illegal class.
    function automatic logic [LEN_W-1:0] kind_len(input vla_kind_t k);
        case (k)
            K_B1:               return 3'd1;
            K_B2:               return 3'd2;
            K_B3_LE, K_B3_BE:   return 3'd3;
            K_B4:               return 3'd4;
            K_B5_CD, K_B5_DC:   return 3'd5;
            K_B6:               return 3'd6;
            K_B7_DD, K_B7_FE:   return 3'd7;
            default:            return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/vla_len_decode.sv
// Module: vla_len_decode
// Classifies the lead byte of an instruction into a packing class.
// Assumes: purely combinational; the caller registers the outcome.
module vla_len_decode
    import vla_pkg::*;
(
    input  logic [7:0] lead,
    output vla_kind_t  kind
);

    logic fields_equal;

    // Register-field comparison used by the 0x80-0xBF row.
    always_comb fields_equal = (lead[3:2] == lead[1:0]);

    // Lead byte to class lookup.
    always_comb begin
        case (lead) inside
            8'h00, 8'h04, 8'h08, 8'h0C, [8'h10:8'h1F], [8'h3C:8'h41],
            8'h44, 8'h45, 8'h48, 8'h49, 8'h4C, 8'h4D, [8'h50:8'h57],
            [8'h60:8'h7F], 8'hCB, [8'hD0:8'hDB], [8'hE0:8'hEF], 8'hFF:
                kind = K_B1;
            [8'h80:8'hBF]:
                kind = fields_equal ? K_B2 : K_B1;
            [8'h20:8'h23], [8'h28:8'h2B], 8'h42, 8'h43, 8'h46, 8'h47,
            8'h4A, 8'h4B, 8'h4E, 8'h4F, [8'h58:8'h5F], [8'hC0:8'hCA],
            8'hCE, 8'hCF, [8'hF0:8'hF6]:
                kind = K_B2;
            [8'h01:8'h03], [8'h05:8'h07], [8'h09:8'h0B], [8'h0D:8'h0F],
            [8'h24:8'h27], [8'h2C:8'h3B], 8'hCC:
                kind = K_B3_LE;
            8'hDE, 8'hDF, 8'hF8, 8'hF9:
                kind = K_B3_BE;
            8'hFA, 8'hFB:
                kind = K_B4;
            8'hCD:
                kind = K_B5_CD;
            8'hDC:
                kind = K_B5_DC;
            8'hFC, 8'hFD:
                kind = K_B6;
            8'hDD:
                kind = K_B7_DD;
            8'hFE:
                kind = K_B7_FE;
            default:
                kind = K_ILL;
        endcase
    end

endmodule

// File: rtl/vla_pack.sv
// Module: vla_pack
// Gathers window bytes into opcode and extension words per class.
// Assumes: WIN_BYTES >= 7; byte i of the window sits at bits [8i+7:8i].
module vla_pack
    import vla_pkg::*;
#(
    parameter int WIN_BYTES = 7
) (
    input  logic [8*WIN_BYTES-1:0] window,
    input  vla_kind_t              kind,
    output logic [OPC_W-1:0]       opcode,
    output logic [EXT_W-1:0]       ext
);

    logic [7:0] b [WIN_BYTES];
    logic       fa_big;

    // Unpack the window into a byte array.
    for (genvar i = 0; i < WIN_BYTES; i++) begin : g_bytes
        assign b[i] = window[8*i +: 8];
    end

    // Detect the 4-byte forms that are entirely big-endian.
    always_comb fa_big = (b[0] == 8'hFA) &&
                         (b[1][7:2] == 6'h3C || b[1][7:2] == 6'h3D ||
                          b[1][7:2] == 6'h3E);

    // Per-class byte placement; unused high bits stay zero.
    always_comb begin
        opcode = '0;
        ext    = '0;
        case (kind)
            K_B1:    opcode = {24'h0, b[0]};
            K_B2:    opcode = {16'h0, b[0], b[1]};
            K_B3_LE: opcode = {8'h0, b[0], b[2], b[1]};
            K_B3_BE: opcode = {8'h0, b[0], b[1], b[2]};
            K_B4:    opcode = fa_big ? {b[0], b[1], b[2], b[3]}
                                     : {b[0], b[1], b[3], b[2]};
            K_B5_CD: begin
                opcode = {b[0], b[2], b[1], b[3]};
                ext    = {16'h0, b[4]};
            end
            K_B5_DC: begin
                opcode = {b[0], b[4], b[3], b[2]};
                ext    = {16'h0, b[1]};
            end
            K_B6: begin
                opcode = {b[0], b[1], b[5], b[4]};
                ext    = {8'h0, b[3], b[2]};
            end
            K_B7_DD: begin
                opcode = {b[0], b[4], b[3], b[2]};
                ext    = {b[1], b[5], b[6]};
            end
            K_B7_FE: begin
                opcode = {b[0], b[1], b[5], b[4]};
                ext    = {b[3], b[2], b[6]};
            end
            default: begin
                opcode = '0;
                ext    = '0;
            end
        endcase
    end

endmodule

// File: rtl/vlen_aligner.sv
// Module: vlen_aligner
// Top of the aligner: classifies the lead byte, packs the words, computes
// the next PC and registers one result per accepted window.
// Assumes: the window always holds at least 7 bytes from in_pc onward.
module vlen_aligner
    import vla_pkg::*;
#(
    parameter int PC_W      = 32,
    parameter int WIN_BYTES = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [PC_W-1:0]        in_pc,
    input  logic [8*WIN_BYTES-1:0] in_window,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [LEN_W-1:0]       out_len,
    output logic [OPC_W-1:0]       out_opcode,
    output logic [EXT_W-1:0]       out_ext,
    output logic                   out_illegal,
    output logic [PC_W-1:0]        out_next_pc
);

    vla_kind_t          kind;
    logic [OPC_W-1:0]   pk_opcode;
    logic [EXT_W-1:0]   pk_ext;
    logic [LEN_W-1:0]   len_c;
    logic [PC_W-1:0]    next_pc_c;
    logic               take;

    vla_len_decode u_decode (
        .lead (in_window[7:0]),
        .kind (kind)
    );

    vla_pack #(.WIN_BYTES(WIN_BYTES)) u_pack (
        .window (in_window),
        .kind   (kind),
        .opcode (pk_opcode),
        .ext    (pk_ext)
    );

    // Ready passes straight through: the single output stage frees when taken.
    always_comb in_ready = out_ready;

    // Handshake: a window is consumed when both sides agree.
    always_comb take = in_valid && out_ready;

    // Length and following address; illegal bytes add zero so the PC holds.
    always_comb begin
        len_c     = kind_len(kind);
        next_pc_c = in_pc + PC_W'(len_c);
    end

    // Output stage: load on take, drop valid when drained, hold when stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_len     <= '0;
            out_opcode  <= '0;
            out_ext     <= '0;
            out_illegal <= 1'b0;
            out_next_pc <= '0;
        end else if (take) begin
            out_valid   <= 1'b1;
            out_len     <= len_c;
            out_opcode  <= pk_opcode;
            out_ext     <= pk_ext;
            out_illegal <= (kind == K_ILL);
            out_next_pc <= next_pc_c;
        end else if (out_ready) begin
            out_valid   <= 1'b0;
        end
    end

    // A taken window shows up as a valid result on the next cycle.
    p_take_shows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && out_ready) |=> out_valid);

    // Stalled results keep every field.
    p_stall_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_opcode) &&
            $stable(out_ext) && $stable(out_len) && $stable(out_next_pc)));

    // Illegal flag and zero length come together.
    p_illegal_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_illegal == (out_len == '0)));

    // Illegal results carry empty words.
    p_illegal_words_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_illegal) |-> (out_opcode == '0 && out_ext == '0));

    // One-byte results leave the upper opcode bytes and extension empty.
    p_short_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_len == 3'd1) |-> (out_opcode[31:8] == '0 && out_ext == '0));

endmodule

// File: tb/vlen_aligner_bench.sv
// Bench: behavioural reference model compared against the aligner each cycle.
module vlen_aligner_bench;

    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 32;
    localparam int WB   = 7;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            in_valid;
    logic            in_ready;
    logic [PC_W-1:0] in_pc;
    logic [8*WB-1:0] in_window;
    logic            out_valid;
    logic            out_ready;
    logic [2:0]      out_len;
    logic [31:0]     out_opcode;
    logic [23:0]     out_ext;
    logic            out_illegal;
    logic [PC_W-1:0] out_next_pc;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    // Expected output register of the model.
    bit          e_valid;
    int          e_len;
    logic [31:0] e_op;
    logic [23:0] e_ext;
    bit          e_ill;
    logic [31:0] e_npc;
    string       e_tag;
    bit          e_stall;

    always #(CLK_PERIOD/2) clk = ~clk;

    vlen_aligner #(.PC_W(PC_W), .WIN_BYTES(WB)) u_vlen_aligner (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_pc(in_pc), .in_window(in_window), .out_valid(out_valid),
        .out_ready(out_ready), .out_len(out_len), .out_opcode(out_opcode),
        .out_ext(out_ext), .out_illegal(out_illegal), .out_next_pc(out_next_pc)
    );

    function automatic bit in_list(input int v, input int lo, input int hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // Reference computation written from the requirements.
    task automatic ref_model(input logic [8*WB-1:0] w, input logic [31:0] pc,
                             output int len, output logic [31:0] op,
                             output logic [23:0] ex, output bit ill,
                             output logic [31:0] npc, output string tag);
        int b [WB];
        int h;
        for (int i = 0; i < WB; i++) b[i] = int'(w[8*i +: 8]);
        h = b[0];
        len = 0; op = 0; ex = 0; ill = 0; tag = "R11";
        if (h >= 'h80 && h <= 'hBF) begin
            tag = "R3";
            if (((h >> 2) & 3) == (h & 3)) begin len = 2; op = (h << 8) | b[1]; end
            else begin len = 1; op = h; end
        end else if (h == 'h00 || h == 'h04 || h == 'h08 || h == 'h0C ||
                     in_list(h, 'h10, 'h1F) || in_list(h, 'h3C, 'h41) ||
                     h == 'h44 || h == 'h45 || h == 'h48 || h == 'h49 ||
                     h == 'h4C || h == 'h4D || in_list(h, 'h50, 'h57) ||
                     in_list(h, 'h60, 'h7F) || h == 'hCB ||
                     in_list(h, 'hD0, 'hDB) || in_list(h, 'hE0, 'hEF) || h == 'hFF) begin
            tag = "R2"; len = 1; op = h;
        end else if (in_list(h, 'h20, 'h23) || in_list(h, 'h28, 'h2B) ||
                     h == 'h42 || h == 'h43 || h == 'h46 || h == 'h47 ||
                     h == 'h4A || h == 'h4B || h == 'h4E || h == 'h4F ||
                     in_list(h, 'h58, 'h5F) || in_list(h, 'hC0, 'hCA) ||
                     h == 'hCE || h == 'hCF || in_list(h, 'hF0, 'hF6)) begin
            tag = "R4"; len = 2; op = (h << 8) | b[1];
        end else if (in_list(h, 'h01, 'h0F) || in_list(h, 'h24, 'h27) ||
                     in_list(h, 'h2C, 'h3B) || h == 'hCC) begin
            tag = "R5"; len = 3; op = (h << 16) | (b[2] << 8) | b[1];
        end else if (h == 'hDE || h == 'hDF || h == 'hF8 || h == 'hF9) begin
            tag = "R6"; len = 3; op = (h << 16) | (b[1] << 8) | b[2];
        end else if (h == 'hFA || h == 'hFB) begin
            tag = "R7"; len = 4;
            h = ((b[0] << 8) | b[1]) & 'hFFFC;
            if (h == 'hFAF0 || h == 'hFAF4 || h == 'hFAF8)
                op = {b[0][7:0], b[1][7:0], b[2][7:0], b[3][7:0]};
            else
                op = {b[0][7:0], b[1][7:0], b[3][7:0], b[2][7:0]};
        end else if (h == 'hCD) begin
            tag = "R8"; len = 5;
            op = {b[0][7:0], b[2][7:0], b[1][7:0], b[3][7:0]}; ex = 24'(b[4]);
        end else if (h == 'hDC) begin
            tag = "R8"; len = 5;
            op = {b[0][7:0], b[4][7:0], b[3][7:0], b[2][7:0]}; ex = 24'(b[1]);
        end else if (h == 'hFC || h == 'hFD) begin
            tag = "R9"; len = 6;
            op = {b[0][7:0], b[1][7:0], b[5][7:0], b[4][7:0]};
            ex = 24'((b[3] << 8) | b[2]);
        end else if (h == 'hDD) begin
            tag = "R10"; len = 7;
            op = {b[0][7:0], b[4][7:0], b[3][7:0], b[2][7:0]};
            ex = {b[1][7:0], b[5][7:0], b[6][7:0]};
        end else if (h == 'hFE) begin
            tag = "R10"; len = 7;
            op = {b[0][7:0], b[1][7:0], b[5][7:0], b[4][7:0]};
            ex = {b[3][7:0], b[2][7:0], b[6][7:0]};
        end else begin
            ill = 1;
        end
        npc = pc + 32'(len);
    endtask

    // Model register: mirrors the handshake rule at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            e_valid = 0; e_stall = 0;
        end else if (in_valid && out_ready) begin
            ref_model(in_window, in_pc, e_len, e_op, e_ext, e_ill, e_npc, e_tag);
            e_valid = 1; e_stall = 0;
        end else if (out_ready) begin
            e_valid = 0; e_stall = 0;
        end else begin
            e_stall = e_valid;
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            n_checks++;
            if (in_ready !== out_ready) begin
                n_fails++;
                $display("FAIL R12 in_ready act=%b exp=%b", in_ready, out_ready);
            end
            n_checks++;
            if (out_valid !== e_valid) begin
                n_fails++;
                $display("FAIL %s out_valid act=%b exp=%b", e_stall ? "R13" : "R12",
                         out_valid, e_valid);
            end else if (e_valid) begin
                n_checks++;
                if (out_len !== 3'(e_len) || out_opcode !== e_op || out_ext !== e_ext ||
                    out_illegal !== e_ill || out_next_pc !== e_npc) begin
                    n_fails++;
                    $display("FAIL %s len/op/ext/ill/npc act=%0d/%h/%h/%b/%h exp=%0d/%h/%h/%b/%h",
                             e_stall ? "R13" : e_tag, out_len, out_opcode, out_ext,
                             out_illegal, out_next_pc, e_len, e_op, e_ext, e_ill, e_npc);
                end
            end
        end
    end

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    endtask

    // Random window with a chosen lead byte and second byte.
    function automatic logic [8*WB-1:0] mk_win(input logic [7:0] lead, input logic [7:0] second);
        logic [8*WB-1:0] w;
        for (int i = 0; i < WB; i++) w[8*i +: 8] = 8'($urandom);
        w[7:0]  = lead;
        w[15:8] = second;
        return w;
    endfunction

    // Stimulus.
    initial begin
        rst_n = 0; in_valid = 0; out_ready = 0; in_pc = '0; in_window = '0;
        repeat (3) @(negedge clk);
        // R1: nothing valid during reset.
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 out_valid in reset act=%b exp=0", out_valid);
        end
        rst_n = 1;
        out_ready = 1;
        @(negedge clk);
        // Sweep every lead byte with random tails (R2..R11), PC near wrap.
        for (int k = 0; k < 256; k++) begin
            in_valid  = 1;
            in_window = mk_win(8'(k), 8'($urandom));
            in_pc     = 32'hFFFF_FFF8 + 32'(k % 16);
            @(negedge clk);
        end
        // Second sweep with second bytes of the big-endian 4-byte form (R7).
        for (int k = 0; k < 256; k++) begin
            in_window = mk_win(8'(k), {6'(6'h3C + k % 3), 2'($urandom)});
            in_pc     = $urandom;
            @(negedge clk);
        end
        // Explicit illegal byte with a stall afterwards (R11, R13).
        in_window = mk_win(8'hF7, 8'h00);
        in_pc     = 32'h0000_1000;
        @(negedge clk);
        out_ready = 0;
        for (int k = 0; k < 4; k++) begin
            in_window = mk_win(8'($urandom), 8'($urandom));
            @(negedge clk);
        end
        out_ready = 1;
        in_valid  = 0;
        repeat (2) @(negedge clk);
        // Random traffic with random valid/ready (R12, R13).
        for (int k = 0; k < 3000; k++) begin
            in_valid  = 1'($urandom);
            out_ready = ($urandom % 4) != 0;
            in_window = mk_win(8'($urandom), 8'($urandom));
            in_pc     = $urandom;
            @(negedge clk);
        end
        summary();
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired act=running exp=done");
            summary();
        end
    end

endmodule